// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor's load/store path. Every lookup compares the virtual page number and the current address-space identifier against every stored entry at the same time. When a valid entry matches on both, the block returns the physical address in the same cycle. That address is the stored frame number with the 12-bit page offset of the virtual address appended. The block also reports a protection fault when a write targets a read-only page. Each hit records use of its entry in a reference bit. A write that is permitted also marks the entry as modified.

When no entry matches, the block raises a miss and takes no further action. A software handler walks the page tables and installs the translation through the refill port. A refill goes to the lowest-numbered empty entry. When no entry is empty, it goes to the entry named by a rotating victim pointer. A flush input invalidates the whole buffer in one clock.

Top module: `vpn_xlate_tlb`

## Requirements
- R1: `hit` is high only when `lk_en` is high and a valid entry matches both `lk_vaddr[31:12]` and `lk_asid`. A matching page under a different ASID does not hit. `hit` and `miss` are never high together, and both are low while `lk_en` is low.
- R2: `miss` is high when `lk_en` is high and no valid entry matches both the virtual page and the ASID.
- R3: On a hit, `pa_out` equals `{stored frame number, lk_vaddr[11:0]}`. Without a hit, `pa_out` is zero.
- R4: `prot_fault` is high when a hit has `lk_write` high and the entry was installed with `rf_writable` low. Reads never fault, and neither do writes to entries installed with `rf_writable` high.
- R5: Every hit sets the matched entry's reference bit at the next clock edge. `hit_ref` and `hit_dirty` show the matched entry's stored bits as they were before the current access, and are zero without a hit.
- R6: A write hit that does not fault sets the entry's dirty bit at the next clock edge. A faulting write and a read leave the dirty bit unchanged.
- R7: A refill (`rf_en` high) writes the lowest-numbered invalid entry when one exists. It installs page, ASID, frame and permission, sets valid, and clears reference and dirty.
- R8: When every entry is valid, a refill replaces the entry named by a victim pointer. The pointer is 0 after reset and advances by one, wrapping, after each such replacement.
- R9: `flush` clears every valid bit in one clock, so the next lookup misses. A refill in the same cycle as a flush is dropped.
- R10: After a synchronous active-low reset, every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the requester |
| lk_write | input | 1 | Access is a store |
| rf_en | input | 1 | Install a translation |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_asid | input | 8 | Owning address space |
| rf_pfn | input | 20 | Physical frame number |
| rf_writable | input | 1 | 1 = read/write page, 0 = read-only page |
| pa_out | output | 32 | Translated physical address |
| hit | output | 1 | Translation found |
| miss | output | 1 | No translation; handler must refill |
| prot_fault | output | 1 | Write to read-only page |
| hit_ref | output | 1 | Matched entry's reference bit before this access |
| hit_dirty | output | 1 | Matched entry's dirty bit before this access |

## Verification
The lookup is tried with the same virtual page under two ASIDs, which separates a tag-only comparator from one that also compares the address space. A neighbouring page and an unknown ASID are also tried; they show whether the full page number and the ASID take part in the match. Repeated reads, writes and faulting writes to one entry show apart the reference update, the dirty update and the suppression of dirty on a fault. Filling every slot and then refilling twice tells the first-invalid choice apart from the rotating victim. Flushing in the same cycle as a refill shows whether the flush takes precedence.

// File: rtl/xlt_pkg.sv
// Shared constants and types for the translation buffer.
// Assumes a 4 KB page; all widths may be overridden at the top.
package xlt_pkg;
    localparam int DEF_VA_W     = 32;
    localparam int DEF_PA_W     = 32;
    localparam int DEF_PAGE_B   = 12;
    localparam int DEF_ASID_W   = 8;
    localparam int DEF_ENTRIES  = 8;

    // Page permission held per entry
    typedef enum logic {
        PERM_RO = 1'b0,
        PERM_RW = 1'b1
    } perm_e;
endpackage

// File: rtl/xlt_entry_bank.sv
// Entry storage and parallel match for the translation buffer.
// Holds per-entry page tag, ASID, frame, permission, valid, reference and dirty.
// Assumes at most one entry matches any (page, ASID) pair.
module xlt_entry_bank
    import xlt_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VPN_W   = DEF_VA_W - DEF_PAGE_B,
    parameter int PFN_W   = DEF_PA_W - DEF_PAGE_B,
    parameter int ASID_W  = DEF_ASID_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     lk_en,
    input  logic [VPN_W-1:0]         lk_vpn,
    input  logic [ASID_W-1:0]        lk_asid,
    input  logic                     lk_write,
    input  logic                     rf_take,
    input  logic [IDX_W-1:0]         rf_idx,
    input  logic [VPN_W-1:0]         rf_vpn,
    input  logic [ASID_W-1:0]        rf_asid,
    input  logic [PFN_W-1:0]         rf_pfn,
    input  perm_e                    rf_perm,
    output logic [ENTRIES-1:0]       match_vec,
    output logic [ENTRIES-1:0]       valid_vec,
    output logic [ENTRIES*PFN_W-1:0] pfn_flat,
    output logic [ENTRIES-1:0]       rw_vec,
    output logic [ENTRIES-1:0]       ref_vec,
    output logic [ENTRIES-1:0]       dirty_vec
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PFN_W-1:0]  pfn_q;
        perm_e             perm_q;
        logic              vld_q;
        logic              ref_q;
        logic              dty_q;
        logic              sel_wr;
        logic              touch;

        // Compare this entry against the lookup key
        always_comb begin
            match_vec[g] = vld_q && (vpn_q == lk_vpn) && (asid_q == lk_asid);
            sel_wr       = rf_take && (rf_idx == IDX_W'(g));
            touch        = lk_en && match_vec[g];
        end

        // Valid bit: reset and flush clear, refill sets
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q <= 1'b0;
            end else if (sel_wr) begin
                vld_q <= 1'b1;
            end
        end

        // Tag, ASID, frame and permission load on refill
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q  <= '0;
                asid_q <= '0;
                pfn_q  <= '0;
                perm_q <= PERM_RO;
            end else if (sel_wr) begin
                vpn_q  <= rf_vpn;
                asid_q <= rf_asid;
                pfn_q  <= rf_pfn;
                perm_q <= rf_perm;
            end
        end

        // Use and modify tracking: refill clears, hits set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_q <= 1'b0;
                dty_q <= 1'b0;
            end else if (sel_wr) begin
                ref_q <= 1'b0;
                dty_q <= 1'b0;
            end else if (touch) begin
                ref_q <= 1'b1;
                if (lk_write && perm_q == PERM_RW) begin
                    dty_q <= 1'b1;
                end
            end
        end

        // Expose stored state to the selector
        always_comb begin
            valid_vec[g]                  = vld_q;
            pfn_flat[g*PFN_W +: PFN_W]    = pfn_q;
            rw_vec[g]                     = (perm_q == PERM_RW);
            ref_vec[g]                    = ref_q;
            dirty_vec[g]                  = dty_q;
        end
    end

endmodule

// File: rtl/xlt_victim_pick.sv
// Chooses the entry a refill writes: lowest invalid entry, else a rotating pointer.
// The pointer moves only when a refill lands on a full buffer.
module xlt_victim_pick #(
    parameter int ENTRIES = xlt_pkg::DEF_ENTRIES,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rf_take,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Priority search for the lowest-numbered empty entry
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        victim_idx = any_free ? free_idx : rr_q;
    end

    // Rotating pointer advances after replacing a live entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (rf_take && !any_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlt_hit_mux.sv
// Folds the one-hot match vector into hit, physical address, fault and status.
// Assumes match_vec has at most one bit set.
module xlt_hit_mux #(
    parameter int ENTRIES = xlt_pkg::DEF_ENTRIES,
    parameter int PFN_W   = xlt_pkg::DEF_PA_W - xlt_pkg::DEF_PAGE_B,
    parameter int PAGE_B  = xlt_pkg::DEF_PAGE_B
) (
    input  logic                     lk_en,
    input  logic                     lk_write,
    input  logic [PAGE_B-1:0]        lk_off,
    input  logic [ENTRIES-1:0]       match_vec,
    input  logic [ENTRIES*PFN_W-1:0] pfn_flat,
    input  logic [ENTRIES-1:0]       rw_vec,
    input  logic [ENTRIES-1:0]       ref_vec,
    input  logic [ENTRIES-1:0]       dirty_vec,
    output logic                     hit,
    output logic                     miss,
    output logic                     prot_fault,
    output logic [PFN_W+PAGE_B-1:0]  pa_out,
    output logic                     hit_ref,
    output logic                     hit_dirty
);

    logic [PFN_W-1:0] pfn_sel;
    logic             rw_sel;

    // AND-OR select of the matching entry's fields
    always_comb begin
        pfn_sel   = '0;
        rw_sel    = 1'b0;
        hit_ref   = 1'b0;
        hit_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_en && match_vec[i]) begin
                pfn_sel   = pfn_sel | pfn_flat[i*PFN_W +: PFN_W];
                rw_sel    = rw_sel | rw_vec[i];
                hit_ref   = hit_ref | ref_vec[i];
                hit_dirty = hit_dirty | dirty_vec[i];
            end
        end
    end

    // Result flags and address assembly
    always_comb begin
        hit        = lk_en && (|match_vec);
        miss       = lk_en && !(|match_vec);
        prot_fault = hit && lk_write && !rw_sel;
        pa_out     = hit ? {pfn_sel, lk_off} : '0;
    end

endmodule

// File: rtl/vpn_xlate_tlb.sv
// Fully associative translation buffer keyed by virtual page and ASID.
// Lookup is combinational; status and refill take effect at the clock edge.
// Flush beats refill in the same cycle. Software must not install duplicates.
module vpn_xlate_tlb
    import xlt_pkg::*;
#(
    parameter int VA_W     = DEF_VA_W,
    parameter int PA_W     = DEF_PA_W,
    parameter int PAGE_B   = DEF_PAGE_B,
    parameter int ASID_W   = DEF_ASID_W,
    parameter int ENTRIES  = DEF_ENTRIES,
    localparam int VPN_W   = VA_W - PAGE_B,
    localparam int PFN_W   = PA_W - PAGE_B,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_en,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic              rf_writable,
    output logic [PA_W-1:0]   pa_out,
    output logic              hit,
    output logic              miss,
    output logic              prot_fault,
    output logic              hit_ref,
    output logic              hit_dirty
);

    logic [ENTRIES-1:0]       match_vec;
    logic [ENTRIES-1:0]       valid_vec;
    logic [ENTRIES*PFN_W-1:0] pfn_flat;
    logic [ENTRIES-1:0]       rw_vec;
    logic [ENTRIES-1:0]       ref_vec;
    logic [ENTRIES-1:0]       dirty_vec;
    logic [IDX_W-1:0]         victim_idx;
    logic                     rf_take;
    perm_e                    rf_perm;

    // Refill qualification and permission encoding
    always_comb begin
        rf_take = rf_en && !flush;
        rf_perm = rf_writable ? PERM_RW : PERM_RO;
    end

    xlt_entry_bank #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_en     (lk_en),
        .lk_vpn    (lk_vaddr[VA_W-1:PAGE_B]),
        .lk_asid   (lk_asid),
        .lk_write  (lk_write),
        .rf_take   (rf_take),
        .rf_idx    (victim_idx),
        .rf_vpn    (rf_vpn),
        .rf_asid   (rf_asid),
        .rf_pfn    (rf_pfn),
        .rf_perm   (rf_perm),
        .match_vec (match_vec),
        .valid_vec (valid_vec),
        .pfn_flat  (pfn_flat),
        .rw_vec    (rw_vec),
        .ref_vec   (ref_vec),
        .dirty_vec (dirty_vec)
    );

    xlt_victim_pick #(
        .ENTRIES (ENTRIES)
    ) victim_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rf_take    (rf_take),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    xlt_hit_mux #(
        .ENTRIES (ENTRIES),
        .PFN_W   (PFN_W),
        .PAGE_B  (PAGE_B)
    ) mux_i (
        .lk_en      (lk_en),
        .lk_write   (lk_write),
        .lk_off     (lk_vaddr[PAGE_B-1:0]),
        .match_vec  (match_vec),
        .pfn_flat   (pfn_flat),
        .rw_vec     (rw_vec),
        .ref_vec    (ref_vec),
        .dirty_vec  (dirty_vec),
        .hit        (hit),
        .miss       (miss),
        .prot_fault (prot_fault),
        .pa_out     (pa_out),
        .hit_ref    (hit_ref),
        .hit_dirty  (hit_dirty)
    );

endmodule

// File: rtl/vpn_xlate_tlb_checker.sv
// Port-level temporal checks for the translation buffer, bound to the top.
module vpn_xlate_tlb_checker #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PAGE_B = 12,
    parameter int ASID_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              lk_en,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_write,
    input logic              rf_en,
    input logic [PA_W-1:0]   pa_out,
    input logic              hit,
    input logic              miss,
    input logic              prot_fault,
    input logic              hit_ref,
    input logic              hit_dirty
);

    // R1: hit and miss are exclusive and idle when no lookup
    a_r1_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |-> (!hit && !miss));

    // R2: a lookup always resolves to hit or miss
    a_r2_lookup_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> (hit || miss));

    // R3: offset passes through untouched on a hit; zero address otherwise
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa_out[PAGE_B-1:0] == lk_vaddr[PAGE_B-1:0]));
    a_r3_no_hit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa_out == '0));

    // R4: a fault needs a write that hit
    a_r4_fault_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (hit && lk_write));

    // R5: a repeat lookup of a page just hit sees its reference bit set
    a_r5_ref_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && !$past(rf_en) && !$past(flush) && lk_en &&
         lk_vaddr[VA_W-1:PAGE_B] == $past(lk_vaddr[VA_W-1:PAGE_B]) &&
         lk_asid == $past(lk_asid)) |-> (hit && hit_ref));

    // R6: a repeat lookup after a permitted write hit sees the dirty bit set
    a_r6_dirty_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && $past(lk_write) && !$past(prot_fault) &&
         !$past(rf_en) && !$past(flush) && lk_en &&
         lk_vaddr[VA_W-1:PAGE_B] == $past(lk_vaddr[VA_W-1:PAGE_B]) &&
         lk_asid == $past(lk_asid)) |-> hit_dirty);

    // R9: nothing hits in the cycle after a flush
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

endmodule

bind vpn_xlate_tlb vpn_xlate_tlb_checker #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .PAGE_B (PAGE_B),
    .ASID_W (ASID_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_en      (lk_en),
    .lk_vaddr   (lk_vaddr),
    .lk_asid    (lk_asid),
    .lk_write   (lk_write),
    .rf_en      (rf_en),
    .pa_out     (pa_out),
    .hit        (hit),
    .miss       (miss),
    .prot_fault (prot_fault),
    .hit_ref    (hit_ref),
    .hit_dirty  (hit_dirty)
);

// File: tb/vpn_xlate_tlb_tb_top.sv
// Self-checking bench: vector table for lookups, then directed refill/flush tests.
module vpn_xlate_tlb_tb_top;
    localparam int CLK_P  = 10;
    localparam int NVEC   = 10;
    // vaddr(32) asid(8) wr(1) hit(1) fault(1) pa(32) ref(1) dirty(1)
    localparam int VEC_W  = 77;

    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {32'h0001_0123, 8'd3, 1'b0, 1'b1, 1'b0, 32'hABCD_E123, 1'b0, 1'b0},
        {32'h0001_0FFF, 8'd3, 1'b1, 1'b1, 1'b0, 32'hABCD_EFFF, 1'b1, 1'b0},
        {32'h0001_0000, 8'd3, 1'b0, 1'b1, 1'b0, 32'hABCD_E000, 1'b1, 1'b1},
        {32'h0001_0456, 8'd5, 1'b0, 1'b1, 1'b0, 32'h1234_5456, 1'b0, 1'b0},
        {32'h0001_0456, 8'd5, 1'b1, 1'b1, 1'b1, 32'h1234_5456, 1'b1, 1'b0},
        {32'h0001_0456, 8'd5, 1'b0, 1'b1, 1'b0, 32'h1234_5456, 1'b1, 1'b0},
        {32'h0001_0456, 8'd7, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        {32'h0001_1123, 8'd3, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        {32'hFA00_0ABC, 8'd3, 1'b0, 1'b1, 1'b0, 32'h0000_3ABC, 1'b0, 1'b0},
        {32'hFA00_0ABC, 8'd4, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_en = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        rf_en = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [7:0]  rf_asid = '0;
    logic [19:0] rf_pfn = '0;
    logic        rf_writable = 1'b0;
    logic [31:0] pa_out;
    logic        hit, miss, prot_fault, hit_ref, hit_dirty;

    int n_chk = 0;
    int n_bad = 0;

    vpn_xlate_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_en(lk_en), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
        .rf_writable(rf_writable),
        .pa_out(pa_out), .hit(hit), .miss(miss), .prot_fault(prot_fault),
        .hit_ref(hit_ref), .hit_dirty(hit_dirty)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [7:0] asid,
                          input logic [19:0] pfn, input logic wr_ok, input logic fl);
        @(negedge clk);
        rf_en = 1'b1; rf_vpn = vpn; rf_asid = asid; rf_pfn = pfn;
        rf_writable = wr_ok; flush = fl;
        @(negedge clk);
        rf_en = 1'b0; flush = 1'b0;
    endtask

    // Drive one lookup, sample mid-cycle, let the edge apply status updates
    task automatic lookup(input string req, input logic [31:0] va, input logic [7:0] asid,
                          input logic wr, input logic e_hit, input logic e_flt,
                          input logic [31:0] e_pa, input logic e_ref, input logic e_dty);
        @(negedge clk);
        lk_en = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr;
        #(CLK_P/4);
        check(req, {27'd0, hit, miss, prot_fault, hit_ref, hit_dirty, pa_out},
                   {27'd0, e_hit, !e_hit, e_flt, e_ref, e_dty, e_pa});
        @(posedge clk);
        #1 lk_en = 1'b0; lk_write = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: empty after reset
        lookup("R10 reset empty", 32'h0001_0123, 8'd3, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);

        refill(20'h00010, 8'd3, 20'hABCDE, 1'b1, 1'b0);
        refill(20'h00010, 8'd5, 20'h12345, 1'b0, 1'b0);
        refill(20'hFA000, 8'd3, 20'h00003, 1'b0, 1'b0);

        // R1: no activity while lk_en low even with a matching address
        @(negedge clk);
        lk_vaddr = 32'h0001_0123; lk_asid = 8'd3;
        #(CLK_P/4);
        check("R1 idle no hit/miss", {62'd0, hit, miss}, 64'd0);

        // R1 R2 R3 R4 R5 R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            lookup($sformatf("R1-table vec %0d (R2 R3 R4 R5 R6)", i),
                   v[76:45], v[44:37], v[36], v[35], v[34], v[33:2], v[1], v[0]);
        end

        // R9: flush with simultaneous refill; everything gone, refill dropped
        refill(20'h000AA, 8'd1, 20'h00BBB, 1'b1, 1'b1);
        lookup("R9 flush clears", 32'h0001_0123, 8'd3, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        lookup("R9 refill dropped", 32'h000A_A000, 8'd1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);

        // R7: fill every slot; each lands in a free entry so all survive
        for (int i = 0; i < 8; i++) begin
            refill(20'h00100 + 20'(i), 8'd1, 20'h00200 + 20'(i), 1'b1, 1'b0);
        end
        for (int i = 0; i < 8; i++) begin
            lookup($sformatf("R7 slot %0d kept", i), {20'h00100 + 20'(i), 12'h010}, 8'd1,
                   1'b0, 1'b1, 1'b0, {20'h00200 + 20'(i), 12'h010}, 1'b0, 1'b0);
        end

        // R8: full buffer, pointer at 0 replaces the first installed page
        refill(20'h00300, 8'd1, 20'h00777, 1'b1, 1'b0);
        lookup("R8 victim 0 evicted", 32'h0010_0000, 8'd1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        lookup("R7 new entry clean", 32'h0030_0044, 8'd1, 1'b0, 1'b1, 1'b0, 32'h0077_7044, 1'b0, 1'b0);
        lookup("R8 neighbour intact", 32'h0010_1000, 8'd1, 1'b0, 1'b1, 1'b0, 32'h0020_1000, 1'b1, 1'b0);

        // R8: pointer advanced to 1
        refill(20'h00301, 8'd1, 20'h00778, 1'b0, 1'b0);
        lookup("R8 victim 1 evicted", 32'h0010_1000, 8'd1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        lookup("R8 slot 2 intact", 32'h0010_2000, 8'd1, 1'b0, 1'b1, 1'b0, 32'h0020_2000, 1'b1, 1'b0);
        lookup("R4 new ro entry faults", 32'h0030_1008, 8'd1, 1'b1, 1'b1, 1'b1, 32'h0077_8008, 1'b0, 1'b0);

        // R10: reset again clears translations
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        lookup("R10 reset clears", 32'h0030_0044, 8'd1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule